// File: doc/BRIEF.md
# Parcel-Fetch Register Core

A small single-issue core that runs an experimental 16-bit-parcel instruction set one instruction at a time. It fetches each instruction as a halfword from a little-endian memory port. When an add-immediate needs its second parcel, it fetches that too. It then executes the instruction over one or more cycles, writing at most one general register per cycle.

The core holds sixteen 32-bit general registers, a 64-bit pair register and a 128-bit quad register. The pair and quad registers are filled from memory or from runs of consecutive general registers, and can be scattered back into those runs. Register index arithmetic wraps modulo 16.

A 4-bit flag set records negative, zero, overflow and carry from register adds. An all-ones instruction halts the core so that a harness can end a run. Each register write appears on a write-trace port, which is the only way to observe the architectural state.

Top module: `pcore`

## Requirements
- R1: While `rst_ni` is low, all registers, flags and the program counter clear to zero and `halt_o` is low. After release, the first request reads address 0.
- R2: The instruction is the halfword `{byte[pc+1], byte[pc]}`. Its fields are op1 = [15:12], op2 = [11:8], destination d = [7:4] and source s = [3:0]. The program counter advances by 2 after each one-parcel instruction.
- R3: op1=4 with op2=0 or 1 writes r[d] = r[d] + r[s] mod 2^32. Both variants give the same result. `flags_o` = {N, Z, V, C}: N is result bit 31, Z is set when the result is zero, V is signed overflow of the original operands, and C is the carry out with carry-in 0. No other instruction changes the flags.
- R4: 0x42ds takes a second parcel at pc+2 as a signed 16-bit value. It writes r[d] = r[s] + that value sign-extended, leaves the flags unchanged, and advances the program counter by 4.
- R5: 0x52ds writes r[d] = r[s] and then r[d+1] = r[s+1], in that order. The second read sees the first write.
- R6: 0x53ds writes the number s, zero-extended, into r[d]. 0x54ds writes r[s+1] into r[d].
- R7: 0x600s loads the pair register as {word(a+4), word(a)}, where a = r[s]. 0x620s writes r[s] = pair[63:32] and then r[s+1] = pair[31:0].
- R8: 0x610s joins the pair register as {word(a), word(a+4)}, so the word at a becomes the upper half.
- R9: 0x630s loads the quad register as {word(a+12), word(a+8), word(a+4), word(a)}. 0x650s writes r[s+k] = quad bits [127-32k -: 32], for k = 0 to 3 in increasing order.
- R10: 0x640s builds the quad register as {r[s], r[s+1], r[s+2], r[s+3]}, with r[s] most significant.
- R11: Any other encoding is a no-op: no register write, no flag change, no data access, and the program counter advances by 2. This includes op1=6 with a non-zero op3 field.
- R12: Instruction 0xFFFF raises `halt_o` permanently. After that there are no requests, no writes and no program counter change.
- R13: `mem_req_o` stays high with a stable `mem_addr_o` until `mem_rvalid_i` is seen. Words read are little-endian. A register write never shares a cycle with a memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_req_o | output | 1 | Read request, held until served |
| mem_addr_o | output | 32 | Byte address of the read |
| mem_rvalid_i | input | 1 | Read data valid for one cycle |
| mem_rdata_i | input | 32 | Little-endian read word |
| rf_we_o | output | 1 | General register write this cycle |
| rf_waddr_o | output | 4 | Index of the written register |
| rf_wdata_o | output | 32 | Value written |
| flags_o | output | 4 | {N, Z, V, C} |
| pc_o | output | 32 | Program counter |
| halt_o | output | 1 | Core halted |

## Verification
Each sweep pass seeds registers with overflow, carry and zero corner words. It then runs every opcode, including overlapping pair moves (d = s+1) and runs that wrap from r15 to r0. The trace is compared against an instruction-level model.

The checks target specific errors. A core that swapped the halves of the pair load and the join would put wrong words into the split registers. A core that read both sources of a pair move before writing would miss the overlap. A core that did not wrap indices would write outside r0 to r15, or read the wrong register. A core that let add-immediate or a no-op touch the flags would show a flag change on a trace entry that should carry none.

Memory latency varies from call to call, so that a request that moves its address or drops early is caught.

// File: rtl/pcore_pkg.sv
package pcore_pkg;
  typedef enum logic [3:0] {
    K_NOP, K_ADD, K_ADDI, K_LDM, K_IFLD, K_IDX,
    K_LD64, K_JN64, K_SP64, K_LD128, K_MK128, K_SP128, K_HALT
  } kind_e;

  typedef enum logic [1:0] {S_FETCH, S_IMM, S_EXEC, S_HALT} state_e;

  localparam logic [15:0] HALT_WORD = 16'hFFFF;
endpackage

// File: rtl/pcore_decode.sv
module pcore_decode
  import pcore_pkg::*;
(
  input  logic [15:0] insn_i,
  output kind_e       kind_o,
  output logic [1:0]  last_o,
  output logic        mem_o
);
  always_comb begin
    kind_o = K_NOP;
    last_o = 2'd0;
    mem_o  = 1'b0;
    case (insn_i[15:12])
      4'h4: case (insn_i[11:8])
        4'h0, 4'h1: kind_o = K_ADD;
        4'h2:       kind_o = K_ADDI;
        default: ;
      endcase
      4'h5: case (insn_i[11:8])
        4'h2: begin kind_o = K_LDM; last_o = 2'd1; end
        4'h3: kind_o = K_IFLD;
        4'h4: kind_o = K_IDX;
        default: ;
      endcase
      4'h6: if (insn_i[7:4] == 4'h0) begin
        case (insn_i[11:8])
          4'h0: begin kind_o = K_LD64;  last_o = 2'd1; mem_o = 1'b1; end
          4'h1: begin kind_o = K_JN64;  last_o = 2'd1; mem_o = 1'b1; end
          4'h2: begin kind_o = K_SP64;  last_o = 2'd1; end
          4'h3: begin kind_o = K_LD128; last_o = 2'd3; mem_o = 1'b1; end
          4'h4: begin kind_o = K_MK128; last_o = 2'd3; end
          4'h5: begin kind_o = K_SP128; last_o = 2'd3; end
          default: ;
        endcase
      end
      4'hF: if (insn_i == HALT_WORD) kind_o = K_HALT;
      default: ;
    endcase
  end
endmodule

// File: rtl/pcore_add.sv
module pcore_add #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] sum_o,
  output logic            c_o,
  output logic            v_o
);
  always_comb begin
    {c_o, sum_o} = {1'b0, a_i} + {1'b0, b_i};
    v_o = (a_i[XLEN-1] == b_i[XLEN-1]) && (sum_o[XLEN-1] != a_i[XLEN-1]);
  end
endmodule

// File: rtl/pcore_rf.sv
module pcore_rf #(
  parameter int XLEN = 32,
  parameter int NREG = 16,
  localparam int RIW = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [RIW-1:0]  waddr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [RIW-1:0]  ra_i,
  output logic [XLEN-1:0] ra_o,
  input  logic [RIW-1:0]  rb_i,
  output logic [XLEN-1:0] rb_o
);
  logic [XLEN-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 regs_q[g] <= '0;
      else if (we_i && (waddr_i == RIW'(g)))       regs_q[g] <= wdata_i;
    end
  end

  assign ra_o = regs_q[ra_i];
  assign rb_o = regs_q[rb_i];
endmodule

// File: rtl/pcore.sv
module pcore
  import pcore_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 16,
  localparam int RIW = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic            mem_req_o,
  output logic [XLEN-1:0] mem_addr_o,
  input  logic            mem_rvalid_i,
  input  logic [XLEN-1:0] mem_rdata_i,
  output logic            rf_we_o,
  output logic [RIW-1:0]  rf_waddr_o,
  output logic [XLEN-1:0] rf_wdata_o,
  output logic [3:0]      flags_o,
  output logic [XLEN-1:0] pc_o,
  output logic            halt_o
);
  state_e          state_q;
  logic [15:0]     ir_q, imm_q;
  logic [1:0]      step_q;
  logic [XLEN-1:0] pc_q;
  logic [3:0]      flags_q;
  logic [XLEN-1:0] pair_q [2];  // [0] = low word
  logic [XLEN-1:0] quad_q [4];

  kind_e           kind;
  logic [1:0]      last;
  logic            is_mem;
  logic [15:0]     dec_in;
  logic [RIW-1:0]  dr, sr, step_r, ra_idx;
  logic [XLEN-1:0] ra, rb, alu_a, alu_b, sum;
  logic            cout, ovf, adv, in_exec;

  assign dec_in = (state_q == S_FETCH) ? mem_rdata_i[15:0] : ir_q;

  pcore_decode u_dec (.insn_i(dec_in), .kind_o(kind), .last_o(last), .mem_o(is_mem));

  assign dr      = ir_q[4 +: RIW];
  assign sr      = ir_q[0 +: RIW];
  assign step_r  = RIW'(step_q);
  assign in_exec = (state_q == S_EXEC);

  always_comb begin
    case (kind)
      K_IDX:           ra_idx = sr + RIW'(1);
      K_LDM, K_MK128:  ra_idx = sr + step_r;
      default:         ra_idx = sr;
    endcase
  end

  pcore_rf #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk_i, .rst_ni,
    .we_i(rf_we_o), .waddr_i(rf_waddr_o), .wdata_i(rf_wdata_o),
    .ra_i(ra_idx), .ra_o(ra), .rb_i(dr), .rb_o(rb)
  );

  assign alu_a = (kind == K_ADDI) ? ra : rb;
  assign alu_b = (kind == K_ADDI) ? {{(XLEN-16){imm_q[15]}}, imm_q} : ra;

  pcore_add #(.XLEN(XLEN)) u_add (.a_i(alu_a), .b_i(alu_b), .sum_o(sum), .c_o(cout), .v_o(ovf));

  // register write port
  always_comb begin
    rf_we_o    = 1'b0;
    rf_waddr_o = dr;
    rf_wdata_o = ra;
    if (in_exec) begin
      case (kind)
        K_ADD, K_ADDI: begin rf_we_o = 1'b1; rf_wdata_o = sum; end
        K_LDM:  begin rf_we_o = 1'b1; rf_waddr_o = dr + step_r; end
        K_IFLD: begin rf_we_o = 1'b1; rf_wdata_o = XLEN'(sr); end
        K_IDX:  rf_we_o = 1'b1;
        K_SP64: begin
          rf_we_o = 1'b1; rf_waddr_o = sr + step_r; rf_wdata_o = pair_q[~step_q[0]];
        end
        K_SP128: begin
          rf_we_o = 1'b1; rf_waddr_o = sr + step_r; rf_wdata_o = quad_q[~step_q];
        end
        default: ;
      endcase
    end
  end

  // memory request
  always_comb begin
    mem_req_o  = 1'b0;
    mem_addr_o = pc_q;
    case (state_q)
      S_FETCH: mem_req_o = 1'b1;
      S_IMM:   begin mem_req_o = 1'b1; mem_addr_o = pc_q + XLEN'(2); end
      S_EXEC:  begin mem_req_o = is_mem; mem_addr_o = ra + XLEN'({step_q, 2'b00}); end
      default: ;
    endcase
  end

  assign adv = is_mem ? mem_rvalid_i : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_FETCH;
      ir_q    <= '0;
      imm_q   <= '0;
      step_q  <= '0;
      pc_q    <= '0;
      flags_q <= '0;
      pair_q  <= '{default: '0};
      quad_q  <= '{default: '0};
    end else begin
      case (state_q)
        S_FETCH: if (mem_rvalid_i) begin
          ir_q    <= mem_rdata_i[15:0];
          state_q <= (kind == K_ADDI) ? S_IMM : S_EXEC;
        end
        S_IMM: if (mem_rvalid_i) begin
          imm_q   <= mem_rdata_i[15:0];
          state_q <= S_EXEC;
        end
        S_EXEC: if (kind == K_HALT) begin
          state_q <= S_HALT;
        end else if (adv) begin
          case (kind)
            K_ADD:   flags_q <= {sum[XLEN-1], sum == '0, ovf, cout};
            K_LD64:  pair_q[step_q[0]]  <= mem_rdata_i;
            K_JN64:  pair_q[~step_q[0]] <= mem_rdata_i;
            K_LD128: quad_q[step_q]     <= mem_rdata_i;
            K_MK128: quad_q[~step_q]    <= ra;
            default: ;
          endcase
          if (step_q == last) begin
            step_q  <= '0;
            pc_q    <= pc_q + ((kind == K_ADDI) ? XLEN'(4) : XLEN'(2));
            state_q <= S_FETCH;
          end else begin
            step_q <= step_q + 2'd1;
          end
        end
        default: ;
      endcase
    end
  end

  assign flags_o = flags_q;
  assign pc_o    = pc_q;
  assign halt_o  = (state_q == S_HALT);
endmodule

// File: rtl/pcore_chk.sv
module pcore_chk #(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            mem_req_o,
  input logic [XLEN-1:0] mem_addr_o,
  input logic            mem_rvalid_i,
  input logic            rf_we_o,
  input logic [3:0]      flags_o,
  input logic [XLEN-1:0] pc_o,
  input logic            halt_o
);
  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o); // R12
  AST_HALT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> (!mem_req_o && !rf_we_o)); // R12
  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o))); // R13
  AST_WRITE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rf_we_o && mem_req_o)); // R13
  AST_FLAGS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rf_we_o |=> $stable(flags_o)); // R3
  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pc_o) |-> ((pc_o - $past(pc_o) == XLEN'(2)) || (pc_o - $past(pc_o) == XLEN'(4)))); // R2
endmodule

bind pcore pcore_chk #(.XLEN(XLEN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
  .mem_rvalid_i(mem_rvalid_i), .rf_we_o(rf_we_o), .flags_o(flags_o),
  .pc_o(pc_o), .halt_o(halt_o)
);

// File: tb/pcore_test.sv
module pcore_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        mem_req, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic        rf_we, halt;
  logic [3:0]  rf_waddr, flags;
  logic [31:0] rf_wdata, pc;

  pcore uut (
    .clk_i(clk), .rst_ni(rst_n), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata), .rf_we_o(rf_we),
    .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata), .flags_o(flags), .pc_o(pc),
    .halt_o(halt)
  );

  logic [7:0] bmem [1024];
  int checks = 0, fails = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd32(input logic [31:0] a);
    logic [9:0] b = a[9:0];
    return {bmem[b + 10'd3], bmem[b + 10'd2], bmem[b + 10'd1], bmem[b]};
  endfunction

  function automatic logic [15:0] rd16(input logic [31:0] a);
    logic [9:0] b = a[9:0];
    return {bmem[b + 10'd1], bmem[b]};
  endfunction

  // memory model with varying latency, driven away from the rising edge
  logic        busy = 1'b0;
  logic [31:0] req_addr = '0;
  int          cnt = 0, lat_sel = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rvalid = 1'b0; busy = 1'b0;
    end else if (mem_rvalid) begin
      mem_rvalid = 1'b0;
    end else if (mem_req) begin
      if (!busy) begin
        busy = 1'b1; req_addr = mem_addr; cnt = lat_sel % 3; lat_sel++;
      end
      if (cnt == 0) begin
        chk("R13", mem_addr, req_addr, "address held until served");
        mem_rdata  = rd32(mem_addr);
        mem_rvalid = 1'b1;
        busy       = 1'b0;
      end else cnt--;
    end
  end

  // write trace capture
  logic [3:0]  log_idx [256];
  logic [31:0] log_dat [256];
  logic [3:0]  log_flg [256];
  int          log_n = 0;
  logic        prev_we = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_we && log_n > 0) log_flg[log_n-1] = flags;
      prev_we = rf_we;
      if (rf_we && log_n < 256) begin
        log_idx[log_n] = rf_waddr; log_dat[log_n] = rf_wdata; log_n++;
      end
    end
  end

  // instruction-level model
  logic [31:0]  rr [16];
  logic [63:0]  rw64;
  logic [127:0] rw128;
  logic [3:0]   rfl;
  logic [3:0]   exp_idx [256];
  logic [31:0]  exp_dat [256];
  logic [3:0]   exp_flg [256];
  string        exp_tag [256];
  int           exp_n;
  logic [31:0]  exp_pc;

  task automatic push(input string tag, input logic [3:0] i, input logic [31:0] d);
    rr[i] = d;
    exp_idx[exp_n] = i; exp_dat[exp_n] = d; exp_flg[exp_n] = rfl; exp_tag[exp_n] = tag;
    exp_n++;
  endtask

  task automatic ref_run();
    logic [31:0] p = '0;
    string t64 = "R7", t128 = "R9";
    for (int k = 0; k < 16; k++) rr[k] = '0;
    rw64 = '0; rw128 = '0; rfl = '0; exp_n = 0;
    for (int n = 0; n < 64; n++) begin
      logic [15:0] ir = rd16(p);
      logic [3:0]  o1 = ir[15:12], o2 = ir[11:8], d = ir[7:4], s = ir[3:0];
      logic [3:0]  d1 = d + 4'd1, s1 = s + 4'd1, s2 = s + 4'd2, s3 = s + 4'd3;
      logic [31:0] a, b, res, adv;
      logic        c, v;
      logic [15:0] imm;
      if (ir == 16'hFFFF) break;
      adv = 32'd2;
      if (o1 == 4'h4 && o2 <= 4'h1) begin
        a = rr[d]; b = rr[s];
        {c, res} = {1'b0, a} + {1'b0, b};
        v = (a[31] == b[31]) && (res[31] != a[31]);
        rfl = {res[31], res == 32'd0, v, c};
        push("R3", d, res);
      end else if (o1 == 4'h4 && o2 == 4'h2) begin
        imm = rd16(p + 32'd2);
        push("R4", d, rr[s] + {{16{imm[15]}}, imm});
        adv = 32'd4;
      end else if (o1 == 4'h5 && o2 == 4'h2) begin
        push("R5", d, rr[s]);
        push("R5", d1, rr[s1]);
      end else if (o1 == 4'h5 && o2 == 4'h3) begin
        push("R6", d, {28'd0, s});
      end else if (o1 == 4'h5 && o2 == 4'h4) begin
        push("R6", d, rr[s1]);
      end else if (o1 == 4'h6 && d == 4'h0) begin
        a = rr[s];
        case (o2)
          4'h0: begin rw64 = {rd32(a + 32'd4), rd32(a)}; t64 = "R7"; end
          4'h1: begin rw64 = {rd32(a), rd32(a + 32'd4)}; t64 = "R8"; end
          4'h2: begin push(t64, s, rw64[63:32]); push(t64, s1, rw64[31:0]); end
          4'h3: begin
            rw128 = {rd32(a + 32'd12), rd32(a + 32'd8), rd32(a + 32'd4), rd32(a)};
            t128 = "R9";
          end
          4'h4: begin rw128 = {rr[s], rr[s1], rr[s2], rr[s3]}; t128 = "R10"; end
          4'h5: begin
            logic [127:0] snap = rw128;
            push(t128, s, snap[127:96]); push(t128, s1, snap[95:64]);
            push(t128, s2, snap[63:32]); push(t128, s3, snap[31:0]);
          end
          default: ;
        endcase
      end
      p = p + adv;
    end
    exp_pc = p;
  endtask

  // program construction
  logic [31:0] wp;
  task automatic emit(input logic [15:0] v);
    bmem[wp[9:0]] = v[7:0]; bmem[wp[9:0] + 10'd1] = v[15:8]; wp = wp + 32'd2;
  endtask

  function automatic logic [31:0] corner(input int i);
    case (i % 8)
      0: return 32'h7FFF_FFFF; 1: return 32'h0000_0001;
      2: return 32'h8000_0000; 3: return 32'hFFFF_FFFF;
      4: return 32'h0000_0000; 5: return 32'h1234_5678;
      6: return 32'h89AB_CDEF; default: return 32'hFFFF_0000;
    endcase
  endfunction

  function automatic logic [15:0] simm(input int i);
    case (i % 8)
      0: return 16'h8000; 1: return 16'h7FFF; 2: return 16'hFFFF; 3: return 16'h0001;
      4: return 16'h0000; 5: return 16'h1234; 6: return 16'hFFFE; default: return 16'h4000;
    endcase
  endfunction

  task automatic build(input int p);
    for (int i = 0; i < 1024; i++) bmem[i] = 8'h00;
    for (int k = 0; k < 4; k++) begin
      logic [31:0] w = corner(p + 3 * k) ^ ((p >= 8) ? 32'h5A5A_5A5A : 32'h0);
      logic [9:0]  ba = 10'h200 + 10'(4 * k);
      bmem[ba] = w[7:0]; bmem[ba + 10'd1] = w[15:8];
      bmem[ba + 10'd2] = w[23:16]; bmem[ba + 10'd3] = w[31:24];
    end
    wp = '0;
    emit(16'h4210); emit(16'h0200);         // r1 = r0 + 0x200
    emit(16'h6301); emit(16'h6504);         // quad load, split to r4..r7
    emit(16'h4045); emit(16'h4167);         // both add forms
    emit(16'h4224); emit(simm(p));          // add-immediate
    emit(16'h5294); emit(16'h5345); emit(16'h54B6);
    emit(16'h6001); emit(16'h620C);         // pair load / split
    emit(16'h6101); emit(16'h620E);         // pair join / split
    emit(16'h640E); emit(16'h650D);         // quad build wraps r14..r1, split wraps r13..r0
    emit(16'h6011); emit(16'h7123); emit(16'h4345); // no-ops
    emit(16'h5232);                         // overlapping pair move
    emit(16'h4045); emit(16'h52F9);         // wrap r15 -> r0
    emit(16'h4099);
    emit(16'hFFFF);
  endtask

  task automatic run_prog(input int p);
    int t, n0;
    build(p);
    ref_run();
    rst_n = 1'b0;
    log_n = 0; prev_we = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", pc, 32'd0, "pc in reset");
    chk("R1", 32'(flags), 32'd0, "flags in reset");
    chk("R1", 32'(halt), 32'd0, "halt in reset");
    chk("R1", 32'(rf_we), 32'd0, "write in reset");
    #3 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 32'(mem_req), 32'd1, "first request");
    chk("R1", mem_addr, 32'd0, "first address");
    t = 0;
    while (!halt && t < 4000) begin @(negedge clk); t++; end
    chk("R12", 32'(halt), 32'd1, "halt reached");
    n0 = log_n;
    repeat (8) @(negedge clk);
    chk("R12", 32'(halt), 32'd1, "halt held");
    chk("R12", 32'(log_n), 32'(n0), "no writes while halted");
    chk("R2", pc, exp_pc, "final pc");
    chk("R11", 32'(log_n), 32'(exp_n), "write count");
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      chk(exp_tag[i], 32'(log_idx[i]), 32'(exp_idx[i]), $sformatf("write %0d index", i));
      chk(exp_tag[i], log_dat[i], exp_dat[i], $sformatf("write %0d data", i));
      chk(exp_tag[i], 32'(log_flg[i]), 32'(exp_flg[i]), $sformatf("write %0d flags", i));
    end
  endtask

  initial begin
    for (int p = 0; p < 12; p++) run_prog(p);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R12 watchdog: got running expected halted");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule